// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits between the read port of a data memory and the register writeback path of a 64-bit integer core. Each request arrives with the raw doubleword returned by memory, the three low bits of the byte address, a two-bit access size and an unsigned flag. The unit picks out the addressed bytes, treating the lowest address as the least significant byte. It then widens the picked value to the 64-bit register width. Signed loads copy the top bit of the picked value into the upper bits. Unsigned loads fill the upper bits with zeros.

An access is misaligned when its address is not a multiple of its size. A build-time parameter decides what happens to such an access. In fault mode the unit raises a misaligned flag and returns zero data. In tolerate mode it serves whatever bytes of the doubleword the access covers. A doubleword request that also carries the unsigned flag has no defined meaning, so the unit reports it as an illegal encoding. The result is registered, with one cycle of latency.

Top module: `load_align_unit`

## Requirements
- R1: Size code 0 selects a byte, 1 a halfword, 2 a word and 3 a doubleword. The byte at offset `addr_lo` of `mem_rdata` (bits 8*addr_lo+7 down to 8*addr_lo) lands in `out_data[7:0]`. Each following byte of the access lands in the next higher byte of `out_data`.
- R2: When `is_unsigned` is 0, every bit of `out_data` above the loaded value is a copy of the loaded value's most significant bit.
- R3: When `is_unsigned` is 1 and the size is below doubleword, every bit of `out_data` above the loaded value is zero.
- R4: A request with size code 3 and `is_unsigned` set raises `out_illegal` together with its result, and `out_data` is zero.
- R5: An access is misaligned when `addr_lo` is not a multiple of the access size in bytes. With `FAULT_ON_MISALIGN` = 1, a misaligned access raises `out_misaligned` for its one result cycle, and `out_data` is zero.
- R6: With `FAULT_ON_MISALIGN` = 0, `out_misaligned` never rises. A misaligned access is served from the bytes of the doubleword at and above `addr_lo`. Byte positions past byte 7 read as zero before extension.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_misaligned` and `out_illegal` are low whenever `out_valid` is low.
- R8: While `rst_n` is low, `out_valid`, `out_misaligned`, `out_illegal` and `out_data` are all zero.
- R9: In a cycle with `in_valid` low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mem_rdata | input | 64 | Raw doubleword from memory |
| addr_lo | input | 3 | Byte offset within the doubleword |
| size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| is_unsigned | input | 1 | Zero-extend instead of sign-extend |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Aligned, extended load value |
| out_misaligned | output | 1 | Misaligned access fault (fault mode only) |
| out_illegal | output | 1 | Unsigned doubleword encoding seen |

## Verification
The assertions assume that `rst_n` is released away from a clock edge. They also assume that the request fields are stable and known whenever `in_valid` is high. They further rely on `in_valid` being a clean level that is not driven during reset.

The stimulus changes every input on the falling clock edge and holds `in_valid` low until reset has been released. It then sweeps every offset, size and sign combination over several data patterns, so each input value it presents is legal and settled at the sampling edge.

// File: rtl/lau_pkg.sv
package lau_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } lau_size_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/lau_byte_select.sv
module lau_byte_select #(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned OFS_W  = $clog2(NBYTES)
) (
  input  logic [NBYTES*8-1:0] word_i,
  input  logic [OFS_W-1:0]    ofs_i,
  output logic [NBYTES*8-1:0] shifted_o
);

  // Each output byte is a mux over every offset; sources past the top read zero.
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] lane;
    always_comb begin
      lane = 8'h00;
      for (int k = 0; k < NBYTES; k++) begin
        if (ofs_i == OFS_W'(k) && (b + k) < NBYTES) begin
          lane = word_i[8*((b+k) % NBYTES) +: 8];
        end
      end
    end
    assign shifted_o[8*b +: 8] = lane;
  end

endmodule

// File: rtl/lau_extend.sv
module lau_extend
  import lau_pkg::*;
#(
  parameter int unsigned NBYTES = 8
) (
  input  logic [NBYTES*8-1:0] shifted_i,
  input  lau_size_e           size_i,
  input  logic                is_unsigned_i,
  output logic [NBYTES*8-1:0] ext_o
);

  logic       top_bit;
  logic       fill_bit;
  logic [3:0] span;

  always_comb begin
    case (size_i)
      SZ_BYTE:  begin top_bit = shifted_i[7];  span = 4'd1; end
      SZ_HALF:  begin top_bit = shifted_i[15]; span = 4'd2; end
      SZ_WORD:  begin top_bit = shifted_i[31]; span = 4'd4; end
      default:  begin top_bit = shifted_i[NBYTES*8-1]; span = 4'(NBYTES); end
    endcase
  end

  assign fill_bit = top_bit & ~is_unsigned_i;

  // Keep the bytes inside the access span; replace the rest with the fill.
  for (genvar b = 0; b < NBYTES; b++) begin : g_fill
    logic keep;
    assign keep = (4'(b) < span);
    assign ext_o[8*b +: 8] = keep ? shifted_i[8*b +: 8] : {8{fill_bit}};
  end

endmodule

// File: rtl/lau_align_check.sv
module lau_align_check
  import lau_pkg::*;
#(
  parameter int unsigned OFS_W = 3
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  lau_size_e        size_i,
  input  logic             is_unsigned_i,
  output logic             misaligned_o,
  output logic             illegal_o
);

  logic [OFS_W-1:0] low_mask;

  always_comb begin
    case (size_i)
      SZ_BYTE:  low_mask = '0;
      SZ_HALF:  low_mask = OFS_W'(1);
      SZ_WORD:  low_mask = OFS_W'(3);
      default:  low_mask = '1;
    endcase
  end

  assign misaligned_o = |(ofs_i & low_mask);
  assign illegal_o    = (size_i == SZ_DWORD) & is_unsigned_i;

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import lau_pkg::*;
#(
  parameter int unsigned XLEN              = 64,
  parameter bit          FAULT_ON_MISALIGN = 1'b1,
  localparam int unsigned NBYTES           = XLEN / 8,
  localparam int unsigned OFS_W            = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic [OFS_W-1:0] addr_lo,
  input  logic [1:0]       size,
  input  logic             is_unsigned,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_data,
  output logic             out_misaligned,
  output logic             out_illegal
);

  lau_size_e        size_e;
  logic [XLEN-1:0]  shifted;
  logic [XLEN-1:0]  extended;
  logic             mis_c;
  logic             ill_c;
  logic             fault_c;

  logic             valid_d, valid_q;
  logic             mis_d,   mis_q;
  logic             ill_d,   ill_q;
  logic [XLEN-1:0]  data_d,  data_q;
  logic             data_en;

  assign size_e = lau_size_e'(size);

  lau_byte_select #(.NBYTES(NBYTES), .OFS_W(OFS_W)) u_sel (
    .word_i    (mem_rdata),
    .ofs_i     (addr_lo),
    .shifted_o (shifted)
  );

  lau_extend #(.NBYTES(NBYTES)) u_ext (
    .shifted_i     (shifted),
    .size_i        (size_e),
    .is_unsigned_i (is_unsigned),
    .ext_o         (extended)
  );

  lau_align_check #(.OFS_W(OFS_W)) u_chk_align (
    .ofs_i         (addr_lo),
    .size_i        (size_e),
    .is_unsigned_i (is_unsigned),
    .misaligned_o  (mis_c),
    .illegal_o     (ill_c)
  );

  // Next-state logic
  always_comb begin
    fault_c = ill_c | (FAULT_ON_MISALIGN & mis_c);
    valid_d = in_valid;
    mis_d   = in_valid & FAULT_ON_MISALIGN & mis_c;
    ill_d   = in_valid & ill_c;
    data_en = in_valid;
    data_d  = fault_c ? '0 : extended;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mis_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mis_q   <= mis_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_data       = data_q;
  assign out_misaligned = mis_q;
  assign out_illegal    = ill_q;

endmodule

// File: rtl/lau_checker.sv
module lau_checker #(
  parameter int unsigned XLEN              = 64,
  parameter bit          FAULT_ON_MISALIGN = 1'b1,
  parameter int unsigned OFS_W             = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [XLEN-1:0]  mem_rdata,
  input logic [OFS_W-1:0] addr_lo,
  input logic [1:0]       size,
  input logic             is_unsigned,
  input logic             out_valid,
  input logic [XLEN-1:0]  out_data,
  input logic             out_misaligned,
  input logic             out_illegal
);

  logic off_grid;
  assign off_grid = ((32'(addr_lo)) % (32'd1 << size)) != 32'd0;

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_misaligned && !out_illegal));

  // R4
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd3 && is_unsigned) |=> (out_illegal && out_data == '0));

  // R5
  misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (FAULT_ON_MISALIGN && in_valid && off_grid) |=> (out_misaligned && out_data == '0));

  // R6
  tolerate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !FAULT_ON_MISALIGN |-> !out_misaligned);

  // R3
  zext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0 && is_unsigned) |=> (out_data[XLEN-1:8] == '0));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

endmodule

bind load_align_unit lau_checker #(
  .XLEN              (XLEN),
  .FAULT_ON_MISALIGN (FAULT_ON_MISALIGN),
  .OFS_W             (OFS_W)
) u_lau_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .mem_rdata      (mem_rdata),
  .addr_lo        (addr_lo),
  .size           (size),
  .is_unsigned    (is_unsigned),
  .out_valid      (out_valid),
  .out_data       (out_data),
  .out_misaligned (out_misaligned),
  .out_illegal    (out_illegal)
);

// File: tb/load_align_unit_bench.sv
module load_align_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] mem_rdata;
  logic [2:0]  addr_lo;
  logic [1:0]  size;
  logic        is_unsigned;

  logic        f_valid, f_mis, f_ill;
  logic [63:0] f_data;
  logic        t_valid, t_mis, t_ill;
  logic [63:0] t_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  load_align_unit #(.XLEN(64), .FAULT_ON_MISALIGN(1'b1)) u_load_align_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mem_rdata(mem_rdata),
    .addr_lo(addr_lo), .size(size), .is_unsigned(is_unsigned),
    .out_valid(f_valid), .out_data(f_data),
    .out_misaligned(f_mis), .out_illegal(f_ill)
  );

  load_align_unit #(.XLEN(64), .FAULT_ON_MISALIGN(1'b0)) u_load_align_unit_tol (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mem_rdata(mem_rdata),
    .addr_lo(addr_lo), .size(size), .is_unsigned(is_unsigned),
    .out_valid(t_valid), .out_data(t_data),
    .out_misaligned(t_mis), .out_illegal(t_ill)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] d, input int a, input int sz,
                                        input bit u, input bit fault);
    int nb;
    bit mis;
    bit ill;
    logic [63:0] s;
    logic [63:0] mask;
    nb  = 1 << sz;
    mis = (a % nb) != 0;
    ill = (sz == 3) && u;
    if (ill || (fault && mis)) return 64'd0;
    s = d >> (a * 8);
    if (nb < 8) begin
      mask = (64'd1 << (nb * 8)) - 64'd1;
      s = s & mask;
      if (!u && s[nb*8-1]) s = s | ~mask;
    end
    return s;
  endfunction

  initial begin
    logic [63:0] pats [4];
    logic [63:0] ef, et;
    bit emf, eif, have;
    pats[0] = 64'hF1E2D3C4B5A69788;
    pats[1] = 64'h0123456789ABCDEF;
    pats[2] = 64'h7F807F80FF0080FF;
    pats[3] = 64'h8000000000000080;
    have = 0; ef = '0; et = '0; emf = 0; eif = 0;

    rst_n = 1'b0; in_valid = 1'b0; mem_rdata = '1; addr_lo = '0; size = '0; is_unsigned = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 valid", {63'd0, f_valid}, 64'd0);
    chk("R8 data", f_data, 64'd0);
    chk("R8 flags", {62'd0, f_mis, f_ill}, 64'd0);
    chk("R8 tol data", t_data, 64'd0);
    rst_n = 1'b1;

    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 8; a++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int u = 0; u < 2; u++) begin
            @(negedge clk);
            if (have) begin
              // R1 R2 R3 R4 R5 R6 R7 result one cycle after request
              chk("R7 valid", {62'd0, f_valid, t_valid}, 64'd3);
              chk("R1 R2 R3 R5 fault data", f_data, ef);
              chk("R6 tolerate data", t_data, et);
              chk("R5 misaligned flag", {63'd0, f_mis}, {63'd0, emf});
              chk("R6 no flag", {63'd0, t_mis}, 64'd0);
              chk("R4 illegal flag", {62'd0, f_ill, t_ill}, {62'd0, eif, eif});
            end
            in_valid = 1'b1; mem_rdata = pats[p]; addr_lo = 3'(a);
            size = 2'(sz); is_unsigned = u[0];
            ef  = model(pats[p], a, sz, u[0], 1'b1);
            et  = model(pats[p], a, sz, u[0], 1'b0);
            emf = (a % (1 << sz)) != 0;
            eif = (sz == 3) && (u == 1);
            have = 1;
          end
        end
      end
    end

    @(negedge clk);
    chk("R7 last valid", {62'd0, f_valid, t_valid}, 64'd3);
    chk("R1 last data", f_data, ef);
    chk("R6 last data", t_data, et);
    // idle cycle with changed fields: data must hold
    in_valid = 1'b0; mem_rdata = 64'h5555AAAA5555AAAA; addr_lo = 3'd0; size = 2'd3; is_unsigned = 1'b1;
    @(negedge clk);
    chk("R7 idle valid", {62'd0, f_valid, t_valid}, 64'd0);
    chk("R7 idle flags", {60'd0, f_mis, f_ill, t_mis, t_ill}, 64'd0);
    chk("R9 hold fault", f_data, ef);
    chk("R9 hold tol", t_data, et);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule